// File: doc/BRIEF.md
# Memory-to-Memory Block Copy Engine

This block copies a run of bytes from one memory region to another. It works as a bus master. A source channel holds the read address and a source count. A destination channel holds the write address and the destination count, which decides how many bytes move. When the copy mode is enabled and a request arrives, the engine raises its bus request and waits for the grant. It then moves bytes one at a time until the block is done.

Each byte takes two four-cycle phases. In the read phase the byte at the source address is latched into an internal holding register. In the write phase that byte is driven to the destination address. Both addresses move by one after each use, up or down, each with its own direction bit. The service ends in one of two ways: the destination count underflows, or the external end-of-process line is asserted. On underflow the engine pulses its end-of-process output, sets a sticky terminal-count flag and masks the destination channel. The mask is not set if the destination channel reloads itself. A source count underflow ends nothing: it only reloads the source when that channel's reload option is on. A source hold option keeps the read address fixed, so that a single byte can fill a block.

Both channels are programmed through a load strobe. The strobe writes the base and the current registers together. A load of the destination channel clears its mask and the terminal-count flag.

Top module: `m2m_copy_engine`

## Requirements
- R1: Reset leaves hrq, mem_rd, mem_wr, eop_out, tc_status and dst_mask low. While cfg_m2m_en is 0, a request never raises hrq.
- R2: A request (req_hw or req_sw, seen at a clock edge while idle and allowed) raises hrq after that edge. No strobe is driven before hlda is seen high. The first mem_rd cycle comes two cycles after the cycle in which hlda is first sampled high.
- R3: Each byte takes a four-cycle read phase and then a four-cycle write phase. In the read phase mem_addr is the source address and mem_rd is high in cycles 2 and 3; the byte on rd_data is latched at the end of cycle 3. In the write phase mem_addr is the destination address, mem_wr is high in cycles 2 and 3, and wr_data carries the latched byte.
- R4: After each byte both addresses step by one. A direction bit of 0 means increment and 1 means decrement (cfg_src_down, cfg_dst_down).
- R5: A destination count of N moves N+1 bytes. During cycle 4 of the final write phase eop_out is high for exactly one cycle. tc_status then becomes 1, and hrq drops in the cycle after that write phase.
- R6: At terminal count dst_mask is set unless cfg_dst_autoinit is 1. While dst_mask is 1, requests are ignored. A destination load clears dst_mask and tc_status. With cfg_dst_autoinit set, the destination address and count return to their loaded values, so the next block writes from the loaded address again.
- R7: A source count underflow drives no eop_out and ends no service. With cfg_src_autoinit set, the next read uses the loaded source address again (period = source count + 1 bytes). Without it, the source address keeps stepping.
- R8: With cfg_src_hold set, every read of the block uses the same source address.
- R9: An eop_in pulse during a service ends it after the write phase of the current byte. This includes a pulse in that phase's last cycle. In that case there is no eop_out and tc_status is not set. An eop_in pulse while idle has no effect on the next block.
- R10: While cfg_verify is 1, requests are ignored and hrq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_m2m_en | input | 1 | Enables memory-to-memory operation |
| cfg_src_hold | input | 1 | Keeps the source address fixed |
| cfg_src_down | input | 1 | Source address direction, 1 = decrement |
| cfg_dst_down | input | 1 | Destination address direction, 1 = decrement |
| cfg_src_autoinit | input | 1 | Source channel reloads on count underflow |
| cfg_dst_autoinit | input | 1 | Destination channel reloads at terminal count |
| cfg_verify | input | 1 | Verify transfer type selected (blocks copy) |
| ld_src | input | 1 | Load source base and current registers |
| ld_dst | input | 1 | Load destination registers, clear mask and flag |
| ld_addr | input | AW | Address value to load |
| ld_count | input | CW | Count value to load (bytes minus one) |
| req_hw | input | 1 | Hardware request for the source channel |
| req_sw | input | 1 | Software request for the source channel |
| hlda | input | 1 | Bus grant |
| hrq | output | 1 | Bus request |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| rd_data | input | DW | Read data from memory |
| wr_data | output | DW | Write data to memory |
| eop_in | input | 1 | External end-of-process |
| eop_out | output | 1 | Terminal count end-of-process pulse |
| tc_status | output | 1 | Sticky destination terminal-count flag |
| dst_mask | output | 1 | Destination channel mask |

## Verification
A wrong phase counter or state shows at the ports within the same byte. The strobes appear in the wrong cycles of the eight-cycle byte window, or hrq fails to fall one cycle after the last write. A corrupted address or count register shows at the next strobe: a write to the wrong address, a wrong byte on wr_data, or a block that is one byte too short or too long. A wrong reload, hold or mask state only shows once the wrap point or the next request is reached. Such cases therefore use short counts and follow-up blocks, so that the fault appears within a few bytes.

// File: rtl/m2m_pkg.sv
package m2m_pkg;

   localparam int unsigned PHASE_LEN = 4;
   localparam int unsigned PH_W      = $clog2(PHASE_LEN);

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_BUSREQ,
      SQ_READ,
      SQ_WRITE
   } seq_state_e;

endpackage

// File: rtl/m2m_chan.sv
module m2m_chan #(
   parameter int unsigned AW      = 16,
   parameter int unsigned CW      = 16,
   parameter bit          HOLD_EN = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] load_addr_i,
   input  logic [CW-1:0] load_cnt_i,
   input  logic          step_i,
   input  logic          down_i,
   input  logic          hold_i,
   input  logic          autoinit_i,
   output logic [AW-1:0] addr_o,
   output logic [CW-1:0] cnt_o,
   output logic          underflow_o
);

   logic [AW-1:0] base_addr_q, cur_addr_q, next_addr;
   logic [CW-1:0] base_cnt_q, cur_cnt_q;
   logic [AW-1:0] moved_addr;

   assign moved_addr  = down_i ? cur_addr_q - AW'(1) : cur_addr_q + AW'(1);
   assign underflow_o = (cur_cnt_q == '0);
   assign addr_o      = cur_addr_q;
   assign cnt_o       = cur_cnt_q;

   generate
      if (HOLD_EN) begin : g_hold
         assign next_addr = hold_i ? cur_addr_q : moved_addr;
      end else begin : g_nohold
         logic unused_hold;
         assign unused_hold = hold_i;
         assign next_addr   = moved_addr;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_addr_q <= '0;
         cur_addr_q  <= '0;
         base_cnt_q  <= '0;
         cur_cnt_q   <= '0;
      end else if (load_i) begin
         base_addr_q <= load_addr_i;
         cur_addr_q  <= load_addr_i;
         base_cnt_q  <= load_cnt_i;
         cur_cnt_q   <= load_cnt_i;
      end else if (step_i) begin
         if (underflow_o && autoinit_i) begin
            cur_addr_q <= base_addr_q;
            cur_cnt_q  <= base_cnt_q;
         end else begin
            cur_addr_q <= next_addr;
            cur_cnt_q  <= cur_cnt_q - CW'(1);
         end
      end
   end

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && !(underflow_o && autoinit_i)) |=> (cnt_o == CW'($past(cnt_o) - CW'(1)))); // R5

   AST_RELOAD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && underflow_o && autoinit_i) |=> (addr_o == $past(base_addr_q))); // R7

   generate
      if (HOLD_EN) begin : g_hold_chk
         AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
            (step_i && hold_i && !load_i && !(underflow_o && autoinit_i)) |=> $stable(addr_o)); // R8
      end
   endgenerate

endmodule

// File: rtl/m2m_seq.sv
module m2m_seq
   import m2m_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic hlda_i,
   input  logic last_i,
   input  logic eop_in_i,
   output logic hrq_o,
   output logic in_read_o,
   output logic rd_o,
   output logic wr_o,
   output logic cap_o,
   output logic src_step_o,
   output logic dst_step_o,
   output logic tc_o
);

   localparam logic [PH_W-1:0] PH_LAST  = PH_W'(PHASE_LEN - 1);
   localparam logic [PH_W-1:0] PH_STB_A = PH_W'(1);
   localparam logic [PH_W-1:0] PH_STB_B = PH_W'(2);

   seq_state_e      st_q, st_d;
   logic [PH_W-1:0] ph_q, ph_d;
   logic            eop_pend_q;
   logic            stop_now;
   logic            strobe_win;

   assign stop_now   = last_i | eop_pend_q | eop_in_i;
   assign strobe_win = (ph_q == PH_STB_A) || (ph_q == PH_STB_B);

   always_comb begin
      st_d = st_q;
      ph_d = ph_q;
      case (st_q)
         SQ_IDLE: begin
            ph_d = '0;
            if (start_i) st_d = SQ_BUSREQ;
         end
         SQ_BUSREQ: begin
            ph_d = '0;
            if (hlda_i) st_d = SQ_READ;
         end
         SQ_READ: begin
            if (ph_q == PH_LAST) begin
               st_d = SQ_WRITE;
               ph_d = '0;
            end else begin
               ph_d = ph_q + PH_W'(1);
            end
         end
         SQ_WRITE: begin
            if (ph_q == PH_LAST) begin
               st_d = stop_now ? SQ_IDLE : SQ_READ;
               ph_d = '0;
            end else begin
               ph_d = ph_q + PH_W'(1);
            end
         end
         default: begin
            st_d = SQ_IDLE;
            ph_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SQ_IDLE;
         ph_q       <= '0;
         eop_pend_q <= 1'b0;
      end else begin
         st_q <= st_d;
         ph_q <= ph_d;
         if (st_q == SQ_IDLE) eop_pend_q <= 1'b0;
         else if (eop_in_i)   eop_pend_q <= 1'b1;
      end
   end

   assign hrq_o      = (st_q != SQ_IDLE);
   assign in_read_o  = (st_q == SQ_READ);
   assign rd_o       = (st_q == SQ_READ)  && strobe_win;
   assign wr_o       = (st_q == SQ_WRITE) && strobe_win;
   assign cap_o      = (st_q == SQ_READ)  && (ph_q == PH_STB_B);
   assign src_step_o = (st_q == SQ_READ)  && (ph_q == PH_LAST);
   assign dst_step_o = (st_q == SQ_WRITE) && (ph_q == PH_LAST);
   assign tc_o       = dst_step_o && last_i;

   AST_STROBE_UNDER_HRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_o || wr_o) |-> hrq_o); // R2

   AST_WAIT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (hrq_o && !in_read_o && !wr_o && !hlda_i && st_q == SQ_BUSREQ) |=> !rd_o); // R2

   AST_TC_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      tc_o |=> !hrq_o); // R5

   AST_EOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_step_o && (eop_in_i || eop_pend_q)) |=> !hrq_o); // R9

   AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      src_step_o |=> (hrq_o && !in_read_o)); // R3

endmodule

// File: rtl/m2m_copy_engine.sv
module m2m_copy_engine #(
   parameter int unsigned AW = 16,
   parameter int unsigned CW = 16,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_m2m_en,
   input  logic          cfg_src_hold,
   input  logic          cfg_src_down,
   input  logic          cfg_dst_down,
   input  logic          cfg_src_autoinit,
   input  logic          cfg_dst_autoinit,
   input  logic          cfg_verify,
   input  logic          ld_src,
   input  logic          ld_dst,
   input  logic [AW-1:0] ld_addr,
   input  logic [CW-1:0] ld_count,
   input  logic          req_hw,
   input  logic          req_sw,
   input  logic          hlda,
   output logic          hrq,
   output logic [AW-1:0] mem_addr,
   output logic          mem_rd,
   output logic          mem_wr,
   input  logic [DW-1:0] rd_data,
   output logic [DW-1:0] wr_data,
   input  logic          eop_in,
   output logic          eop_out,
   output logic          tc_status,
   output logic          dst_mask
);

   generate
      if (AW < 2) begin : g_bad_aw
         $error("m2m_copy_engine: AW must be at least 2");
      end
      if (CW < 1) begin : g_bad_cw
         $error("m2m_copy_engine: CW must be at least 1");
      end
      if (DW < 1) begin : g_bad_dw
         $error("m2m_copy_engine: DW must be at least 1");
      end
   endgenerate

   logic          start;
   logic          in_read, cap, src_step, dst_step, tc_evt;
   logic [AW-1:0] src_addr, dst_addr;
   logic [CW-1:0] unused_src_cnt, unused_dst_cnt;
   logic          unused_src_uf;
   logic          dst_last;
   logic [DW-1:0] hold_byte_q;
   logic          tc_q, mask_q;

   assign start = cfg_m2m_en && !cfg_verify && !mask_q && (req_hw || req_sw);

   m2m_chan #(.AW(AW), .CW(CW), .HOLD_EN(1'b1)) i_src_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (ld_src),
      .load_addr_i (ld_addr),
      .load_cnt_i  (ld_count),
      .step_i      (src_step),
      .down_i      (cfg_src_down),
      .hold_i      (cfg_src_hold),
      .autoinit_i  (cfg_src_autoinit),
      .addr_o      (src_addr),
      .cnt_o       (unused_src_cnt),
      .underflow_o (unused_src_uf)
   );

   m2m_chan #(.AW(AW), .CW(CW), .HOLD_EN(1'b0)) i_dst_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (ld_dst),
      .load_addr_i (ld_addr),
      .load_cnt_i  (ld_count),
      .step_i      (dst_step),
      .down_i      (cfg_dst_down),
      .hold_i      (1'b0),
      .autoinit_i  (cfg_dst_autoinit),
      .addr_o      (dst_addr),
      .cnt_o       (unused_dst_cnt),
      .underflow_o (dst_last)
   );

   m2m_seq i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .hlda_i     (hlda),
      .last_i     (dst_last),
      .eop_in_i   (eop_in),
      .hrq_o      (hrq),
      .in_read_o  (in_read),
      .rd_o       (mem_rd),
      .wr_o       (mem_wr),
      .cap_o      (cap),
      .src_step_o (src_step),
      .dst_step_o (dst_step),
      .tc_o       (tc_evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_byte_q <= '0;
         tc_q        <= 1'b0;
         mask_q      <= 1'b0;
      end else begin
         if (cap) hold_byte_q <= rd_data;
         if (ld_dst) begin
            tc_q   <= 1'b0;
            mask_q <= 1'b0;
         end else if (tc_evt) begin
            tc_q <= 1'b1;
            if (!cfg_dst_autoinit) mask_q <= 1'b1;
         end
      end
   end

   assign mem_addr  = in_read ? src_addr : dst_addr;
   assign wr_data   = hold_byte_q;
   assign eop_out   = tc_evt;
   assign tc_status = tc_q;
   assign dst_mask  = mask_q;

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!hrq && !cfg_m2m_en) |=> !hrq); // R1

   AST_MASK_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!hrq && dst_mask && !ld_dst) |=> !hrq); // R6

   AST_VERIFY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!hrq && cfg_verify) |=> !hrq); // R10

   AST_TC_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (eop_out && !ld_dst) |=> tc_status); // R5

   AST_EOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      eop_out |=> !eop_out); // R5

endmodule

// File: tb/test_m2m_copy_engine.sv
module test_m2m_copy_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_m2m_en = 1'b0, cfg_src_hold = 1'b0, cfg_src_down = 1'b0, cfg_dst_down = 1'b0;
   logic        cfg_src_autoinit = 1'b0, cfg_dst_autoinit = 1'b0, cfg_verify = 1'b0;
   logic        ld_src = 1'b0, ld_dst = 1'b0;
   logic [15:0] ld_addr = '0, ld_count = '0;
   logic        req_hw = 1'b0, req_sw = 1'b0, hlda = 1'b0, eop_in = 1'b0;
   logic        hrq, mem_rd, mem_wr, eop_out, tc_status, dst_mask;
   logic [15:0] mem_addr;
   logic [7:0]  rd_data, wr_data;

   int checks = 0;
   int fails  = 0;
   int hlda_delay = 0;
   int grant_cnt  = 0;
   int g_gap = 0;
   bit finished = 1'b0;

   logic [15:0] m_src_base, m_src_cnt, m_dst_base;
   bit          m_src_down, m_dst_down, m_hold, m_src_ai;

   always #4 clk = ~clk;

   function automatic logic [7:0] pat(input logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
   endfunction

   assign rd_data = pat(mem_addr);

   m2m_copy_engine i_m2m_copy_engine (
      .clk(clk), .rst_n(rst_n), .cfg_m2m_en(cfg_m2m_en), .cfg_src_hold(cfg_src_hold),
      .cfg_src_down(cfg_src_down), .cfg_dst_down(cfg_dst_down),
      .cfg_src_autoinit(cfg_src_autoinit), .cfg_dst_autoinit(cfg_dst_autoinit),
      .cfg_verify(cfg_verify), .ld_src(ld_src), .ld_dst(ld_dst), .ld_addr(ld_addr),
      .ld_count(ld_count), .req_hw(req_hw), .req_sw(req_sw), .hlda(hlda), .hrq(hrq),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .rd_data(rd_data),
      .wr_data(wr_data), .eop_in(eop_in), .eop_out(eop_out), .tc_status(tc_status),
      .dst_mask(dst_mask)
   );

   // bus grant responder: grants hlda_delay+1 samples after hrq is seen
   always @(negedge clk) begin
      if (hrq) begin
         grant_cnt = grant_cnt + 1;
         hlda = (grant_cnt > hlda_delay);
      end else begin
         grant_cnt = 0;
         hlda = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_src(input int i);
      int j;
      j = m_src_ai ? (i % (int'(m_src_cnt) + 1)) : i;
      if (m_hold) return m_src_base;
      return m_src_down ? m_src_base - 16'(j) : m_src_base + 16'(j);
   endfunction

   function automatic logic [15:0] exp_dst(input int i);
      return m_dst_down ? m_dst_base - 16'(i) : m_dst_base + 16'(i);
   endfunction

   task automatic load_chan(input bit dst, input logic [15:0] a, input logic [15:0] c);
      @(negedge clk);
      ld_addr = a; ld_count = c;
      if (dst) ld_dst = 1'b1; else ld_src = 1'b1;
      @(negedge clk);
      ld_dst = 1'b0; ld_src = 1'b0;
      if (dst) begin m_dst_base = a; end
      else begin m_src_base = a; m_src_cnt = c; end
   endtask

   task automatic set_cfg(input bit sd, input bit dd, input bit hold, input bit sai, input bit dai);
      @(negedge clk);
      cfg_src_down = sd; cfg_dst_down = dd; cfg_src_hold = hold;
      cfg_src_autoinit = sai; cfg_dst_autoinit = dai;
      m_src_down = sd; m_dst_down = dd; m_hold = hold; m_src_ai = sai;
   endtask

   // request pulse, then no hrq for six samples
   task automatic expect_ignored(input string req, input bit hw);
      bit seen;
      seen = 1'b0;
      @(negedge clk);
      if (hw) req_hw = 1'b1; else req_sw = 1'b1;
      @(negedge clk);
      req_hw = 1'b0; req_sw = 1'b0;
      if (hrq) seen = 1'b1;
      repeat (5) begin
         @(negedge clk);
         if (hrq) seen = 1'b1;
      end
      chk(!seen, req, "request ignored, hrq", seen, 0);
   endtask

   // run one block; eop_at > 0 pulses eop_in at that sample index
   task automatic run_block(input bit hw, input int exp_bytes, input bit exp_tc,
                            input int eop_at, input string src_tag);
      int t, rd_i, wr_i, eops, first_hrq, first_rd;
      bit prd, pwr, seen;
      t = 0; rd_i = 0; wr_i = 0; eops = 0; first_hrq = -1; first_rd = -1;
      prd = 1'b0; pwr = 1'b0; seen = 1'b0;
      @(negedge clk);
      if (hw) req_hw = 1'b1; else req_sw = 1'b1;
      while (1) begin
         @(negedge clk);
         t++;
         if (t == 1) begin req_hw = 1'b0; req_sw = 1'b0; end
         eop_in = (eop_at > 0 && t == eop_at);
         if (hrq && first_hrq < 0) first_hrq = t;
         if (mem_rd && first_rd < 0) first_rd = t;
         if (mem_rd && !prd) begin
            chk(mem_addr == exp_src(rd_i), src_tag, "read address", mem_addr, exp_src(rd_i));
            rd_i++;
         end
         if (mem_wr && !pwr) begin
            chk(mem_addr == exp_dst(wr_i), "R4", "write address", mem_addr, exp_dst(wr_i));
            chk(wr_data == pat(exp_src(wr_i)), "R3", "write data", wr_data, pat(exp_src(wr_i)));
            wr_i++;
         end
         if (eop_out) eops++;
         prd = mem_rd; pwr = mem_wr;
         if (hrq) seen = 1'b1;
         if (seen && !hrq) break;
         if (t > 4000) begin
            chk(1'b0, "R5", "block timeout", t, 0);
            break;
         end
      end
      eop_in = 1'b0;
      g_gap = first_rd - first_hrq;
      chk(g_gap == hlda_delay + 2, "R2", "hrq to first read", g_gap, hlda_delay + 2);
      chk(wr_i == exp_bytes, eop_at > 0 ? "R9" : "R5", "bytes moved", wr_i, exp_bytes);
      chk(eops == (exp_tc ? 1 : 0), exp_tc ? "R5" : "R9", "eop_out cycles", eops, exp_tc ? 1 : 0);
      chk(tc_status == exp_tc, exp_tc ? "R5" : "R9", "tc_status", tc_status, exp_tc);
   endtask

   initial begin
      logic [9:0]  v_hrq, v_rd, v_wr, v_eop;
      logic [15:0] a_rd, a_wr;
      logic [7:0]  d_wr;
      logic [15:0] ra, rb, rc, rd;
      bit          b0, b1, b2, b3, b4, b5;
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      chk(hrq == 0 && mem_rd == 0 && mem_wr == 0 && eop_out == 0, "R1", "reset outputs",
          {hrq, mem_rd, mem_wr, eop_out}, 0);
      chk(tc_status == 0 && dst_mask == 0, "R1", "reset status", {tc_status, dst_mask}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: disabled engine ignores requests
      load_chan(0, 16'h0010, 16'd5);
      load_chan(1, 16'h0080, 16'd0);
      expect_ignored("R1", 1'b0);

      // R3 cycle trace of a single-byte block
      set_cfg(0, 0, 0, 0, 0);
      cfg_m2m_en = 1'b1;
      hlda_delay = 0;
      a_rd = '0; a_wr = '0; d_wr = '0;
      @(negedge clk);
      req_sw = 1'b1;
      for (int n = 1; n <= 10; n++) begin
         @(negedge clk);
         req_sw = 1'b0;
         v_hrq[n-1] = hrq; v_rd[n-1] = mem_rd; v_wr[n-1] = mem_wr; v_eop[n-1] = eop_out;
         if (n == 3) a_rd = mem_addr;
         if (n == 7) begin a_wr = mem_addr; d_wr = wr_data; end
      end
      chk(v_hrq == 10'b0111111111, "R3", "hrq trace", v_hrq, 10'b0111111111);
      chk(v_rd  == 10'b0000001100, "R3", "mem_rd trace", v_rd, 10'b0000001100);
      chk(v_wr  == 10'b0011000000, "R3", "mem_wr trace", v_wr, 10'b0011000000);
      chk(v_eop == 10'b0100000000, "R5", "eop_out trace", v_eop, 10'b0100000000);
      chk(a_rd == 16'h0010, "R3", "read phase address", a_rd, 16'h0010);
      chk(a_wr == 16'h0080, "R3", "write phase address", a_wr, 16'h0080);
      chk(d_wr == pat(16'h0010), "R3", "latched byte", d_wr, pat(16'h0010));
      chk(tc_status == 1, "R5", "tc_status after trace", tc_status, 1);
      chk(dst_mask == 1, "R6", "mask after TC", dst_mask, 1);

      // R6: masked channel ignores requests, load clears
      expect_ignored("R6", 1'b1);
      load_chan(1, 16'h0100, 16'd3);
      chk(dst_mask == 0 && tc_status == 0, "R6", "load clears mask and flag",
          {dst_mask, tc_status}, 0);

      // R2 with a slow grant, R4 decrementing destination
      hlda_delay = 3;
      set_cfg(0, 1, 0, 0, 0);
      load_chan(0, 16'h0300, 16'd9);
      run_block(1'b1, 4, 1'b1, 0, "R4");
      hlda_delay = 0;

      // R7 source autoinit wraps every three bytes
      set_cfg(0, 0, 0, 1, 0);
      load_chan(0, 16'h0400, 16'd2);
      load_chan(1, 16'h0500, 16'd6);
      run_block(1'b0, 7, 1'b1, 0, "R7");

      // R7 without autoinit the source keeps stepping past underflow
      set_cfg(1, 0, 0, 0, 0);
      load_chan(0, 16'h0600, 16'd1);
      load_chan(1, 16'h0700, 16'd4);
      run_block(1'b0, 5, 1'b1, 0, "R7");

      // R8 source hold fills a block with one byte
      set_cfg(0, 1, 1, 0, 0);
      load_chan(0, 16'h0123, 16'd0);
      load_chan(1, 16'h0900, 16'd5);
      run_block(1'b1, 6, 1'b1, 0, "R8");

      // R6 destination autoinit: no mask, second block restarts destination
      set_cfg(0, 0, 0, 0, 1);
      load_chan(0, 16'h0A00, 16'd20);
      load_chan(1, 16'h0B00, 16'd2);
      run_block(1'b0, 3, 1'b1, 0, "R4");
      chk(dst_mask == 0, "R6", "autoinit keeps mask clear", dst_mask, 0);
      m_src_base = 16'h0A03;
      run_block(1'b0, 3, 1'b1, 0, "R6");

      // R9 external end in a read phase, in the last write cycle, and while idle
      set_cfg(0, 0, 0, 0, 0);
      load_chan(0, 16'h0C00, 16'd30);
      load_chan(1, 16'h0D00, 16'd9);
      run_block(1'b0, 3, 1'b0, 20, "R4");
      chk(dst_mask == 0, "R9", "no mask after external end", dst_mask, 0);
      load_chan(0, 16'h0C00, 16'd30);
      load_chan(1, 16'h0D00, 16'd9);
      run_block(1'b0, 3, 1'b0, 25, "R4");
      @(negedge clk); eop_in = 1'b1;
      @(negedge clk); eop_in = 1'b0;
      load_chan(0, 16'h0E00, 16'd30);
      load_chan(1, 16'h0F00, 16'd3);
      run_block(1'b1, 4, 1'b1, 0, "R9");

      // R10 verify type blocks the copy
      load_chan(1, 16'h0F00, 16'd3);
      @(negedge clk); cfg_verify = 1'b1;
      expect_ignored("R10", 1'b0);
      @(negedge clk); cfg_verify = 1'b0;

      // constrained random blocks
      for (int it = 0; it < 30; it++) begin
         ra = 16'($urandom); rb = 16'($urandom);
         rc = 16'($urandom_range(0, 6)); rd = 16'($urandom_range(0, 9));
         b0 = 1'($urandom); b1 = 1'($urandom); b2 = ($urandom_range(0, 3) == 0);
         b3 = 1'($urandom); b4 = 1'($urandom); b5 = 1'($urandom);
         hlda_delay = int'($urandom_range(0, 3));
         set_cfg(b0, b1, b2, b3, b4);
         load_chan(0, ra, rc);
         load_chan(1, rb, rd);
         run_block(b5, int'(rd) + 1, 1'b1, 0, b2 ? "R8" : (b3 ? "R7" : "R4"));
         chk(dst_mask == !b4, "R6", "mask after random block", dst_mask, !b4);
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule